// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits in the digital output path of a data converter, after the sample has been produced and before the output formatter. On every sample that is marked valid it either forwards the live converter word or puts a known test word in its place. Downstream capture logic can then check its wiring, bit ordering and timing against a predictable sequence. The test words are a constant low level, a constant high level, an alternating checkerboard, an incrementing ramp, and a custom word that software loads as two separate fields.

Live samples arrive in two's complement. A format select turns them into offset binary by flipping the most significant bit. Test words bypass this conversion and always appear exactly as defined. The output word and its valid flag are registered, with one cycle of latency. The ramp and the checkerboard keep their own sequence state. That state moves forward only on valid samples and restarts each time its mode is entered again.

Top module: `adc_tpg`

## Requirements
- R1: With `pat_sel` = 3'b000 and `fmt_obin` = 0, a valid input sample appears unchanged on `out_word`.
- R2: `pat_sel` = 3'b001 outputs all zeros (0x0000); `pat_sel` = 3'b010 outputs all ones (0x3FFF at 14 bits).
- R3: `pat_sel` = 3'b011 alternates between 0x2AAA (odd bits set) and 0x1555 (even bits set) on successive valid samples, and always starts with 0x2AAA on the first valid sample after the mode is entered.
- R4: `pat_sel` = 3'b100 outputs a ramp that rises by one code on each valid sample. It starts at 0x0000 on the first valid sample after the mode is entered.
- R5: The ramp wraps from 0x3FFF back to 0x0000.
- R6: `pat_sel` = 3'b101 outputs the custom word: bits [6:0] are taken from `cust_lo` and bits [13:7] from `cust_hi`.
- R7: The reserved codes 3'b110 and 3'b111 behave exactly like 3'b000, including the format conversion.
- R8: With `fmt_obin` = 1, live samples come out with bit 13 inverted (offset binary). Test patterns are not affected by `fmt_obin`.
- R9: `out_vld` equals `smp_vld` one clock later. A new `pat_sel` or `fmt_obin` value takes effect on the first valid sample that carries it.
- R10: While `smp_vld` is 0, `out_word` holds its value and the ramp and checkerboard sequences do not advance.
- R11: A synchronous reset clears `out_word` and `out_vld` to 0, and the ramp and checkerboard sequences start from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Input sample valid (clock enable) |
| smp_word | input | DATA_W (14) | Live sample, two's complement |
| pat_sel | input | 3 | Pattern select |
| fmt_obin | input | 1 | 1 = offset binary for live samples |
| cust_lo | input | LO_W (7) | Custom word, low field |
| cust_hi | input | DATA_W-LO_W (7) | Custom word, high field |
| out_word | output | DATA_W (14) | Registered output word |
| out_vld | output | 1 | Registered output valid |

## Verification
The bench checks that the ramp and the checkerboard restart when their mode is left and entered again. A design that kept the old state would carry on mid-sequence after re-entry. It also runs invalid gaps through both sequences: a design that counted every clock would skip codes, and one that did not hold the output would show stale or changed words. The ramp is driven through a full wrap from 0x3FFF to 0x0000, and the format bit is set while test patterns are selected; a design that applied the MSB flip to patterns would corrupt them. The reserved codes are also checked against live passthrough in both formats.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;

    typedef enum logic [2:0] {
        SEL_LIVE    = 3'd0,
        SEL_ZERO    = 3'd1,
        SEL_ONES    = 3'd2,
        SEL_CHECKER = 3'd3,
        SEL_RAMP    = 3'd4,
        SEL_CUSTOM  = 3'd5,
        SEL_RSV6    = 3'd6,
        SEL_RSV7    = 3'd7
    } pat_sel_e;

    // Source category that the output mux steers on
    typedef enum logic [2:0] {
        SRC_LIVE,
        SRC_ZERO,
        SRC_ONES,
        SRC_CHECKER,
        SRC_RAMP,
        SRC_CUSTOM
    } src_e;

    function automatic src_e decode_sel(input logic [2:0] sel);
        src_e s;
        case (pat_sel_e'(sel))
            SEL_ZERO:    s = SRC_ZERO;
            SEL_ONES:    s = SRC_ONES;
            SEL_CHECKER: s = SRC_CHECKER;
            SEL_RAMP:    s = SRC_RAMP;
            SEL_CUSTOM:  s = SRC_CUSTOM;
            default:     s = SRC_LIVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_tpg_seq.sv
// Holds the ramp counter and checkerboard phase; both restart on mode entry.
module adc_tpg_seq
    import adc_tpg_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  src_e              src,
    output logic [DATA_W-1:0] ramp_now,
    output logic              chk_phase_now
);
    logic              prev_ramp_q;
    logic              prev_chk_q;
    logic [DATA_W-1:0] cnt_q;
    logic              phase_q;

    assign ramp_now      = prev_ramp_q ? cnt_q : '0;
    assign chk_phase_now = prev_chk_q ? phase_q : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ramp_q <= 1'b0;
            prev_chk_q  <= 1'b0;
            cnt_q       <= '0;
            phase_q     <= 1'b0;
        end else if (adv) begin
            prev_ramp_q <= (src == SRC_RAMP);
            prev_chk_q  <= (src == SRC_CHECKER);
            if (src == SRC_RAMP) begin
                cnt_q <= ramp_now + 1'b1;
            end
            if (src == SRC_CHECKER) begin
                phase_q <= ~chk_phase_now;
            end
        end
    end
endmodule

// File: rtl/adc_tpg_fmt.sv
// Number format for live samples: offset binary flips the sign bit.
module adc_tpg_fmt #(
    parameter int DATA_W = 14
) (
    input  logic [DATA_W-1:0] live_in,
    input  logic              obin,
    output logic [DATA_W-1:0] live_out
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        live_out      = live_in;
        live_out[MSB] = live_in[MSB] ^ obin;
    end
endmodule

// File: rtl/adc_tpg_mux.sv
// Selects the next output word from live data or one of the test sources.
module adc_tpg_mux
    import adc_tpg_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int LO_W   = 7
) (
    input  src_e              src,
    input  logic [DATA_W-1:0] live_fmt,
    input  logic [DATA_W-1:0] ramp_now,
    input  logic              chk_phase,
    input  logic [LO_W-1:0]   cust_lo,
    input  logic [DATA_W-LO_W-1:0] cust_hi,
    output logic [DATA_W-1:0] word_nxt
);
    logic [DATA_W-1:0] chk_odd;
    logic [DATA_W-1:0] chk_even;

    for (genvar i = 0; i < DATA_W; i++) begin : g_chk
        assign chk_odd[i]  = (i % 2) == 1;
        assign chk_even[i] = (i % 2) == 0;
    end

    always_comb begin
        case (src)
            SRC_ZERO:    word_nxt = '0;
            SRC_ONES:    word_nxt = '1;
            SRC_CHECKER: word_nxt = chk_phase ? chk_even : chk_odd;
            SRC_RAMP:    word_nxt = ramp_now;
            SRC_CUSTOM:  word_nxt = {cust_hi, cust_lo};
            default:     word_nxt = live_fmt;
        endcase
    end
endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
    import adc_tpg_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int LO_W   = 7,
    localparam int HI_W  = DATA_W - LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_word,
    input  logic [2:0]        pat_sel,
    input  logic              fmt_obin,
    input  logic [LO_W-1:0]   cust_lo,
    input  logic [HI_W-1:0]   cust_hi,
    output logic [DATA_W-1:0] out_word,
    output logic              out_vld
);
    src_e              src;
    logic [DATA_W-1:0] ramp_now;
    logic              chk_phase;
    logic [DATA_W-1:0] live_fmt;
    logic [DATA_W-1:0] word_nxt;

    assign src = decode_sel(pat_sel);

    adc_tpg_seq #(.DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .adv           (smp_vld),
        .src           (src),
        .ramp_now      (ramp_now),
        .chk_phase_now (chk_phase)
    );

    adc_tpg_fmt #(.DATA_W(DATA_W)) u_fmt (
        .live_in  (smp_word),
        .obin     (fmt_obin),
        .live_out (live_fmt)
    );

    adc_tpg_mux #(.DATA_W(DATA_W), .LO_W(LO_W)) u_mux (
        .src       (src),
        .live_fmt  (live_fmt),
        .ramp_now  (ramp_now),
        .chk_phase (chk_phase),
        .cust_lo   (cust_lo),
        .cust_hi   (cust_hi),
        .word_nxt  (word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                out_word <= word_nxt;
            end
        end
    end
endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk #(
    parameter int DATA_W = 14,
    parameter int LO_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [DATA_W-1:0] smp_word,
    input logic [2:0]        pat_sel,
    input logic              fmt_obin,
    input logic [LO_W-1:0]   cust_lo,
    input logic [DATA_W-LO_W-1:0] cust_hi,
    input logic [DATA_W-1:0] out_word,
    input logic              out_vld
);
    logic last_ramp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ramp_q <= 1'b0;
        end else if (smp_vld) begin
            last_ramp_q <= (pat_sel == 3'b100);
        end
    end

    a_r1_passthrough: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && pat_sel == 3'b000 && !fmt_obin) |=> out_word == $past(smp_word));

    a_r2_zero: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && pat_sel == 3'b001) |=> out_word == '0);

    a_r2_ones: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && pat_sel == 3'b010) |=> out_word == '1);

    // R4 and R5: each ramp step is the previous ramp word plus one, modulo the width
    a_r4_ramp_step: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && pat_sel == 3'b100 && last_ramp_q)
        |=> out_word == DATA_W'($past(out_word) + 1'b1));

    a_r6_custom: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && pat_sel == 3'b101) |=> out_word == {$past(cust_hi), $past(cust_lo)});

    a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_vld == $past(smp_vld));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(out_word));
endmodule

bind adc_tpg adc_tpg_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) u_adc_tpg_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_word (smp_word),
    .pat_sel  (pat_sel),
    .fmt_obin (fmt_obin),
    .cust_lo  (cust_lo),
    .cust_hi  (cust_hi),
    .out_word (out_word),
    .out_vld  (out_vld)
);

// File: tb/adc_tpg_bench.sv
module adc_tpg_bench;
    localparam int W = 14;

    logic          clk = 1'b0;
    logic          rst;
    logic          smp_vld;
    logic [W-1:0]  smp_word;
    logic [2:0]    pat_sel;
    logic          fmt_obin;
    logic [6:0]    cust_lo;
    logic [6:0]    cust_hi;
    logic [W-1:0]  out_word;
    logic          out_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    adc_tpg u_adc_tpg (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_word(smp_word),
        .pat_sel(pat_sel), .fmt_obin(fmt_obin), .cust_lo(cust_lo),
        .cust_hi(cust_hi), .out_word(out_word), .out_vld(out_vld)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, then step past the edge
    task automatic step(input logic v, input logic [2:0] sel, input logic [W-1:0] w);
        smp_vld  = v;
        pat_sel  = sel;
        smp_word = w;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; smp_vld = 1'b1; pat_sel = 3'b010; smp_word = 14'h1234;
        fmt_obin = 1'b0; cust_lo = '0; cust_hi = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R11 word", out_word, '0);
        check("R11 vld", {13'd0, out_vld}, 14'd1 - 14'd1);
        rst = 1'b0;
    endtask

    task automatic t_live();
        logic [W-1:0] pats [4] = '{14'h0000, 14'h1FFF, 14'h2000, 14'h3A5C};
        fmt_obin = 1'b0;
        foreach (pats[i]) begin
            step(1'b1, 3'b000, pats[i]);
            check("R1 live", out_word, pats[i]);
            check("R9 vld", {13'd0, out_vld}, 14'd1);
        end
    endtask

    task automatic t_const();
        fmt_obin = 1'b1;
        step(1'b1, 3'b001, 14'h3FFF);
        check("R2 zeros", out_word, 14'h0000);
        check("R8 zeros unaffected", out_word, 14'h0000);
        step(1'b1, 3'b010, 14'h0000);
        check("R2 ones", out_word, 14'h3FFF);
        fmt_obin = 1'b0;
    endtask

    task automatic t_checker();
        step(1'b1, 3'b011, 14'h0);
        check("R3 first", out_word, 14'h2AAA);
        step(1'b1, 3'b011, 14'h0);
        check("R3 second", out_word, 14'h1555);
        step(1'b0, 3'b011, 14'h0);
        check("R10 hold chk", out_word, 14'h1555);
        step(1'b1, 3'b011, 14'h0);
        check("R3 third after gap", out_word, 14'h2AAA);
        step(1'b1, 3'b011, 14'h0);
        check("R3 fourth", out_word, 14'h1555);
        step(1'b1, 3'b000, 14'h0101);
        check("R9 mode change", out_word, 14'h0101);
        step(1'b1, 3'b011, 14'h0);
        check("R3 restart", out_word, 14'h2AAA);
    endtask

    task automatic t_ramp();
        fmt_obin = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 3'b100, 14'h3333);
            check("R4 ramp", out_word, 14'(k));
        end
        step(1'b0, 3'b100, 14'h0);
        step(1'b0, 3'b100, 14'h0);
        check("R10 hold ramp", out_word, 14'd4);
        check("R9 vld low", {13'd0, out_vld}, 14'd0);
        step(1'b1, 3'b100, 14'h0);
        check("R10 no advance", out_word, 14'd5);
        step(1'b1, 3'b101, 14'h0);
        step(1'b1, 3'b100, 14'h0);
        check("R4 restart", out_word, 14'd0);
        fmt_obin = 1'b0;
    endtask

    task automatic t_wrap();
        step(1'b1, 3'b001, 14'h0);
        for (int k = 0; k < 16384; k++) begin
            step(1'b1, 3'b100, 14'h0);
        end
        check("R5 top", out_word, 14'h3FFF);
        step(1'b1, 3'b100, 14'h0);
        check("R5 wrap", out_word, 14'h0000);
        step(1'b1, 3'b100, 14'h0);
        check("R5 after wrap", out_word, 14'h0001);
    endtask

    task automatic t_custom();
        cust_lo = 7'h55; cust_hi = 7'h2B; fmt_obin = 1'b1;
        step(1'b1, 3'b101, 14'h0);
        check("R6 custom", out_word, {7'h2B, 7'h55});
        check("R8 custom unaffected", out_word, 14'h15D5);
        cust_lo = 7'h7F; cust_hi = 7'h00;
        step(1'b1, 3'b101, 14'h0);
        check("R6 custom low only", out_word, 14'h007F);
        fmt_obin = 1'b0;
    endtask

    task automatic t_format();
        fmt_obin = 1'b1;
        step(1'b1, 3'b000, 14'h0000);
        check("R8 obin zero", out_word, 14'h2000);
        step(1'b1, 3'b000, 14'h2000);
        check("R8 obin min", out_word, 14'h0000);
        step(1'b1, 3'b110, 14'h1FFF);
        check("R7 rsv6 obin", out_word, 14'h3FFF);
        fmt_obin = 1'b0;
        step(1'b1, 3'b111, 14'h2468);
        check("R7 rsv7 live", out_word, 14'h2468);
        step(1'b1, 3'b110, 14'h1357);
        check("R7 rsv6 live", out_word, 14'h1357);
    endtask

    task automatic t_rst_mid();
        step(1'b1, 3'b100, 14'h0);
        step(1'b1, 3'b100, 14'h0);
        rst = 1'b1;
        step(1'b1, 3'b100, 14'h0);
        check("R11 mid word", out_word, 14'h0);
        rst = 1'b0;
        step(1'b1, 3'b100, 14'h0);
        check("R11 ramp restart", out_word, 14'h0);
        step(1'b1, 3'b100, 14'h0);
        check("R11 ramp next", out_word, 14'h1);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_live();
        t_const();
        t_checker();
        t_ramp();
        t_wrap();
        t_custom();
        t_format();
        t_rst_mid();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule